// File: doc/BRIEF.md
# Paired-Diagonal Parity Encoder

This block protects a 64-bit word against multi-bit upsets by attaching 27 check bits to it. The word is viewed as an 8x8 bit grid, where bit index `r*8 + c` sits at row `r`, column `c`. Each row gets an even parity bit, and so does each column. A third family of parities runs along diagonals. Each step of a diagonal covers two horizontally adjacent bits, so a row holds four pair-cells. The encoder writes the data and the check bits into one 91-bit codeword, which a separate decoder can later use to locate and repair upsets.

All three parity families come from the same data in parallel, in pure combinational logic. An output stage then either passes the codeword straight through or holds it in a register. In registered mode the codeword is captured on each clock edge that sees a valid input. A one-bit valid flag runs alongside it. The codeword bit order is fixed, and a matching decoder depends on it.

Top module: `pdp_encoder`

## Requirements
- R1: Codeword bits [63:0] equal the input data bits [63:0] unchanged.
- R2: Codeword bit 64+r (r = 0..7) is the even parity of data bits r*8 through r*8+7.
- R3: Codeword bit 72+c (c = 0..7) is the even parity of data bits c, c+8, ..., c+56.
- R4: Codeword bit 80+d (d = 0..10) is the even parity of every data bit at row r, column c with d = r - c/2 + 3. Diagonal 0 is the top-right pair (bits 6 and 7), and diagonal 10 is the bottom-left pair (bits 56 and 57).
- R5: The two bits of a pair-cell (columns 2k and 2k+1 of one row) always fall in the same diagonal. Flipping both bits together leaves every row and diagonal check bit unchanged and toggles exactly two column check bits.
- R6: With the register enabled, a word presented with in_valid high appears on out_code after the next rising clock edge, and out_valid is high for exactly the cycles that follow a captured word.
- R7: With the register enabled, out_code keeps its value across any clock edge where in_valid is low, whatever in_data carries.
- R8: The synchronous active-high reset drives out_valid low at the next edge.
- R9: The all-zeros and all-ones data words both yield an all-zero 27-bit check field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset, clears the valid flag |
| in_valid | input | 1 | Qualifies in_data for capture |
| in_data | input | 64 | Data word to encode |
| out_valid | output | 1 | Marks out_code as holding a captured codeword |
| out_code | output | 91 | Diagonals [90:80], columns [79:72], rows [71:64], data [63:0] |

## Verification
The first patterns are single-bit words at the four grid corners (bits 0, 7, 56 and 63). Each one lights exactly one row, one column and one diagonal check bit, so any mistake in diagonal numbering or in field placement shows up at once. A word that sets only one horizontal pair separates pair-cell diagonals from single-bit diagonals, because the diagonal field must stay zero. The all-zeros and all-ones words catch inverted (odd) parity. A batch of pseudo-random words, compared against an independent model, covers the remaining mixed cases. Directed sequences with in_valid held low, and with reset asserted in mid-run, show the capture, hold and valid-flag behaviour.

// File: rtl/pdp_pkg.sv
package pdp_pkg;

    // Grid geometry; both dimensions must be even
    localparam int GRID_ROWS = 8;
    localparam int GRID_COLS = 8;

    localparam int DATA_W    = GRID_ROWS * GRID_COLS;
    localparam int PAIRS     = GRID_COLS / 2;
    localparam int DIAGS     = GRID_ROWS + PAIRS - 1;
    localparam int CHECK_W   = GRID_ROWS + GRID_COLS + DIAGS;
    localparam int CODE_W    = DATA_W + CHECK_W;

    // Codeword layout, most significant field first
    typedef struct packed {
        logic [DIAGS-1:0]     diag;
        logic [GRID_COLS-1:0] col;
        logic [GRID_ROWS-1:0] row;
        logic [DATA_W-1:0]    data;
    } codeword_t;

    // Diagonal that holds the bit at (r, c), counted from the top-right pair
    function automatic int diag_of(input int r, input int c, input int pairs);
        return r - (c / 2) + pairs - 1;
    endfunction

endpackage

// File: rtl/pdp_line_parity.sv
module pdp_line_parity #(
    parameter int ROWS = pdp_pkg::GRID_ROWS,
    parameter int COLS = pdp_pkg::GRID_COLS,
    localparam int DW  = ROWS * COLS
) (
    input  logic [DW-1:0]   data,
    output logic [ROWS-1:0] row_par,
    output logic [COLS-1:0] col_par
);

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign row_par[r] = ^data[r*COLS +: COLS];
    end

    for (genvar c = 0; c < COLS; c++) begin : g_col
        always_comb begin
            logic acc;
            acc = 1'b0;
            for (int r = 0; r < ROWS; r++) begin
                acc = acc ^ data[r*COLS + c];
            end
            col_par[c] = acc;
        end
    end

endmodule

// File: rtl/pdp_diag_parity.sv
module pdp_diag_parity #(
    parameter int ROWS = pdp_pkg::GRID_ROWS,
    parameter int COLS = pdp_pkg::GRID_COLS,
    localparam int DW  = ROWS * COLS,
    localparam int NP  = COLS / 2,
    localparam int ND  = ROWS + NP - 1
) (
    input  logic [DW-1:0] data,
    output logic [ND-1:0] diag_par
);

    for (genvar d = 0; d < ND; d++) begin : g_diag
        always_comb begin
            logic acc;
            acc = 1'b0;
            for (int r = 0; r < ROWS; r++) begin
                for (int c = 0; c < COLS; c++) begin
                    if (pdp_pkg::diag_of(r, c, NP) == d) begin
                        acc = acc ^ data[r*COLS + c];
                    end
                end
            end
            diag_par[d] = acc;
        end
    end

endmodule

// File: rtl/pdp_out_stage.sv
module pdp_out_stage #(
    parameter int  W          = pdp_pkg::CODE_W,
    parameter bit  REGISTERED = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_code,
    output logic         out_valid,
    output logic [W-1:0] out_code
);

    if (REGISTERED) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                out_valid <= 1'b0;
            end else begin
                out_valid <= in_valid;
            end
        end

        always_ff @(posedge clk) begin
            if (in_valid && !rst) begin
                out_code <= in_code;
            end
        end

        // R8
        reset_clears_valid_chk: assert property (@(posedge clk)
            rst |=> !out_valid);

        // R6
        capture_sets_valid_chk: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> (out_valid && out_code == $past(in_code)));

        // R6
        idle_clears_valid_chk: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> !out_valid);

        // R7
        idle_holds_code_chk: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> $stable(out_code));
    end else begin : g_comb
        assign out_valid = in_valid;
        assign out_code  = in_code;
    end

endmodule

// File: rtl/pdp_encoder.sv
module pdp_encoder #(
    parameter bit REGISTERED = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [pdp_pkg::DATA_W-1:0] in_data,
    output logic                       out_valid,
    output logic [pdp_pkg::CODE_W-1:0] out_code
);
    import pdp_pkg::*;

    logic [GRID_ROWS-1:0] row_par;
    logic [GRID_COLS-1:0] col_par;
    logic [DIAGS-1:0]     diag_par;
    codeword_t            code;

    pdp_line_parity #(.ROWS(GRID_ROWS), .COLS(GRID_COLS)) line_i (
        .data    (in_data),
        .row_par (row_par),
        .col_par (col_par)
    );

    pdp_diag_parity #(.ROWS(GRID_ROWS), .COLS(GRID_COLS)) diag_i (
        .data     (in_data),
        .diag_par (diag_par)
    );

    always_comb begin
        code.data = in_data;
        code.row  = row_par;
        code.col  = col_par;
        code.diag = diag_par;
    end

    pdp_out_stage #(.W(CODE_W), .REGISTERED(REGISTERED)) out_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_code   (code),
        .out_valid (out_valid),
        .out_code  (out_code)
    );

    // R2 R3 R4: each family covers every data bit once, so the three
    // overall parities drawn from separate generators must agree
    families_agree_chk: assert property (@(posedge clk) disable iff (rst)
        (^row_par == ^col_par) && (^col_par == ^diag_par));

endmodule

// File: tb/pdp_encoder_tb.sv
`timescale 1ns/1ps
module pdp_encoder_tb_top;

    localparam int DW = 64;
    localparam int CW = 91;
    localparam int NV = 7;

    // Directed vectors: data and expected 27-bit check field
    // check field = {diag[10:0], col[7:0], row[7:0]}
    localparam logic [DW-1:0] VEC_DATA [NV] = '{
        64'h0000_0000_0000_0000,   // R9 zeros
        64'hFFFF_FFFF_FFFF_FFFF,   // R9 ones
        64'h0000_0000_0000_0001,   // bit 0: row0 col0 diag3
        64'h8000_0000_0000_0000,   // bit 63: row7 col7 diag7
        64'h0000_0000_0000_0080,   // bit 7: row0 col7 diag0
        64'h0100_0000_0000_0000,   // bit 56: row7 col0 diag10
        64'h0000_0000_0000_0003    // R5 pair bits 0,1
    };
    localparam logic [26:0] VEC_CHK [NV] = '{
        27'h0000000,
        27'h0000000,
        27'h0080101,
        27'h0808080,
        27'h0018001,
        27'h4000180,
        27'h0000300
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          out_valid;
    logic [CW-1:0] out_code;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    pdp_encoder dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_code  (out_code)
    );

    function automatic logic [26:0] model(input logic [DW-1:0] x);
        logic [26:0] chk;
        chk = '0;
        for (int r = 0; r < 8; r++) begin
            for (int c = 0; c < 8; c++) begin
                if (x[r*8+c]) begin
                    chk[r]                  = ~chk[r];
                    chk[8 + c]              = ~chk[8 + c];
                    chk[16 + r - c/2 + 3]   = ~chk[16 + r - c/2 + 3];
                end
            end
        end
        return chk;
    endfunction

    task automatic check(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [DW-1:0] x);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = x;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [DW-1:0] seed;
        logic [CW-1:0] held;
        logic [26:0]   base;

        repeat (3) @(negedge clk);
        check("R8 reset valid", CW'(out_valid), CW'(0));
        rst = 1'b0;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            apply(VEC_DATA[i]);
            check("R1 data field", CW'(out_code[63:0]), CW'(VEC_DATA[i]));
            check("R2 row field", CW'(out_code[71:64]), CW'(VEC_CHK[i][7:0]));
            check("R3 col field", CW'(out_code[79:72]), CW'(VEC_CHK[i][15:8]));
            check("R4 diag field", CW'(out_code[90:80]), CW'(VEC_CHK[i][26:16]));
            check("R6 valid after capture", CW'(out_valid), CW'(1));
        end

        // R5: flip each pair in turn on a random base
        seed = 64'h1234_5678_9ABC_DEF1;
        base = model(seed);
        for (int k = 0; k < 32; k++) begin
            logic [DW-1:0] x;
            logic [26:0]   e;
            x = seed ^ (64'h3 << (2*k));
            e = base;
            e[8 + (2*k)%8]     = ~e[8 + (2*k)%8];
            e[8 + (2*k)%8 + 1] = ~e[8 + (2*k)%8 + 1];
            apply(x);
            check("R5 pair flip", CW'(out_code[90:64]), CW'(e));
        end

        // Random words vs model (R2 R3 R4)
        for (int i = 0; i < 24; i++) begin
            seed = {seed[62:0], seed[63] ^ seed[62] ^ seed[60] ^ seed[59]} * 64'd6364136223846793005 + 64'd1442695040888963407;
            apply(seed);
            check("R4 random codeword", out_code, {model(seed), seed});
        end

        // R6 valid drops when idle; R7 code holds
        apply(64'hDEAD_BEEF_0123_4567);
        held = out_code;
        @(negedge clk);
        in_data = 64'hFFFF_0000_FFFF_0000;
        check("R6 valid low when idle", CW'(out_valid), CW'(0));
        @(negedge clk);
        @(negedge clk);
        check("R7 code holds while idle", out_code, held);

        // R8 mid-run reset
        @(negedge clk);
        in_valid = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        check("R8 reset mid-run", CW'(out_valid), CW'(0));
        rst = 1'b0;
        in_valid = 1'b0;
        apply(64'h0000_0000_0000_0001);
        check("R6 valid after reset release", CW'(out_valid), CW'(1));
        check("R4 corner after reset", CW'(out_code[90:64]), CW'(27'h0080101));

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule